// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block watches a small microcontroller core for loss of control. A counter advances once per machine cycle from the moment power-on reset is released. When it reaches a parameterised timeout count it wraps to zero, and, if the watchdog is armed, a one-cycle CPU reset request is issued and a status flag is latched. Software keeps the core alive by restarting the count at checkpoints in its code. The arm bit only decides whether a timeout produces a reset. The counter always runs.

The arm bit and the restart bit sit in a control register. Ordinary writes to that register cannot change them. Software must first write a two-byte key to a separate access register. That opens a short window in which exactly one control write is accepted. The arm bit is treated as nonvolatile: a power-on reset event clears the counter, the unlock state and the status flag, but the arm bit keeps its value. Only the storage reset `rst_ni`, which models a blank part, clears it. While stop mode is active, the counter is frozen and no reset request is issued.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_ni` is released, `cpu_rst_o`, `wdt_en_o`, `wdt_restart_o` and `wdt_flag_o` are all 0.
- R2: With the arm bit set, `cpu_rst_o` is high for exactly one cycle, TIMEOUT cycles after the count was last cleared. The count restarts from zero at that point, so an unserviced watchdog fires every TIMEOUT cycles.
- R3: The counter runs and wraps whatever the arm bit is. With the arm bit clear no reset is issued. Arming part-way through an interval produces the reset at the end of that same interval.
- R4: An accepted control write with bit 1 set clears the count. A full TIMEOUT interval follows. `wdt_restart_o` reads 1 in the cycle after the write and 0 in the cycle after that.
- R5: The access register is at address 0 and the control register at address 1. Control bit 0 is arm, bit 1 is restart and bit 2 is the status flag. Writing 0xAA and then 0x55 to address 0 unlocks the control register. After 0xAA, the 0x55 must arrive within 3 cycles. After 0x55, one control write in the following 3 cycles is accepted and loads the arm bit from bit 0.
- R6: A control write made without an open window leaves the arm bit unchanged and does not restart the count.
- R7: The window closes in three cases: a non-key value is written to address 0, 0x55 arrives without a preceding 0xAA, or one control write has been accepted. A control write 4 cycles after the 0x55 is rejected.
- R8: A timeout with the arm bit set raises `wdt_flag_o`. The flag stays set until a control write (unlocked or not) has bit 2 clear, or until `por_i` is pulsed.
- R9: While `stop_i` is high the count holds its value and `cpu_rst_o` stays low. When `stop_i` falls, counting resumes from the held value.
- R10: A `por_i` pulse clears the count and the status flag but keeps the arm bit. A watchdog reset also keeps the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine-cycle clock |
| rst_ni | input | 1 | Active-low asynchronous storage reset (clears everything, including the arm bit) |
| por_i | input | 1 | Power-on reset event, synchronous; the arm bit is kept |
| stop_i | input | 1 | Stop mode; freezes the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (0 access, 1 control) |
| wr_data_i | input | 8 | Write data |
| cpu_rst_o | output | 1 | One-cycle CPU reset request |
| wdt_en_o | output | 1 | Arm bit |
| wdt_restart_o | output | 1 | Restart bit readback (self-clearing) |
| wdt_flag_o | output | 1 | Watchdog-reset status flag |

## Verification
Register fields update at the clock edge that samples the write. The bench writes on one falling edge and reads the field at the next falling edge. The restart readback is checked there and again one edge later. Reset timing is measured in whole cycles from the edge that cleared the count. A reset request is due TIMEOUT edges after the clearing write, shifted later by the number of edges spent in stop mode. The bench therefore counts falling edges until `cpu_rst_o` is seen and compares that count with the figure worked out from the stimulus. It also checks the cycle right after the pulse, so a pulse wider than one cycle is caught.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic [1:0] {UL_IDLE, UL_KEY, UL_OPEN} ul_state_e;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_RS_BIT  = 1;
  localparam int CTL_FLG_BIT = 2;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_keyed_pkg::*;
#(
  parameter int WINDOW   = 3,
  parameter int ADDR_W   = 2,
  parameter int ACC_ADDR = 0,
  parameter int CTL_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              grant_o
);
  localparam int LEFT_W = $clog2(WINDOW + 1);

  ul_state_e         st_q;
  logic [LEFT_W-1:0] left_q;
  logic              acc_wr, ctl_wr;

  assign acc_wr  = wr_en_i && (wr_addr_i == ADDR_W'(ACC_ADDR));
  assign ctl_wr  = wr_en_i && (wr_addr_i == ADDR_W'(CTL_ADDR));
  assign grant_o = (st_q == UL_OPEN) && ctl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= UL_IDLE;
      left_q <= '0;
    end else if (clr_i) begin
      st_q   <= UL_IDLE;
      left_q <= '0;
    end else if (acc_wr) begin
      if (wr_data_i == KEY_FIRST) begin
        st_q   <= UL_KEY;
        left_q <= LEFT_W'(WINDOW);
      end else if (wr_data_i == KEY_SECOND && st_q == UL_KEY) begin
        st_q   <= UL_OPEN;
        left_q <= LEFT_W'(WINDOW);
      end else begin
        st_q <= UL_IDLE;
      end
    end else if (grant_o) begin
      st_q <= UL_IDLE;  // one protected write per unlock
    end else if (st_q != UL_IDLE) begin
      if (left_q == LEFT_W'(1)) st_q <= UL_IDLE;
      else left_q <= left_q - LEFT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TIMEOUT = 122800,
  parameter int CNT_W   = $clog2(TIMEOUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             stop_i,
  input  logic             restart_i,
  output logic             tmo_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tmo_o = !stop_i && (cnt_q == CNT_W'(TIMEOUT - 1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (por_i || restart_i)  cnt_q <= '0;
    else if (stop_i)              cnt_q <= cnt_q;
    else if (tmo_o)               cnt_q <= '0;  // wraps whether armed or not
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_keyed_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       ctl_wr_i,
  input  logic       grant_i,
  input  logic [2:0] data_i,
  input  logic       tmo_i,
  output logic       en_o,
  output logic       restart_o,
  output logic       flag_o,
  output logic       cpu_rst_o
);
  logic en_q, rs_q, flg_q, rst_q;

  // arm bit: nonvolatile model, only storage reset or an unlocked write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (grant_i) en_q <= data_i[CTL_EN_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q  <= 1'b0;
      flg_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs_q  <= grant_i && data_i[CTL_RS_BIT];
      rst_q <= !por_i && tmo_i && en_q;
      if (por_i)                              flg_q <= 1'b0;
      else if (tmo_i && en_q)                 flg_q <= 1'b1;
      else if (ctl_wr_i && !data_i[CTL_FLG_BIT]) flg_q <= 1'b0;
    end
  end

  assign en_o      = en_q;
  assign restart_o = rs_q;
  assign flag_o    = flg_q;
  assign cpu_rst_o = rst_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int TIMEOUT  = 122800,
  parameter int WINDOW   = 3,
  parameter int ADDR_W   = 2,
  parameter int ACC_ADDR = 0,
  parameter int CTL_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              cpu_rst_o,
  output logic              wdt_en_o,
  output logic              wdt_restart_o,
  output logic              wdt_flag_o
);
  localparam int CNT_W = $clog2(TIMEOUT);

  logic             ta_grant, ctl_wr, tmo;
  logic [CNT_W-1:0] cnt;

  assign ctl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTL_ADDR));

  wdt_unlock #(
    .WINDOW(WINDOW), .ADDR_W(ADDR_W), .ACC_ADDR(ACC_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_unlock (
    .clk_i, .rst_ni, .clr_i(por_i), .wr_en_i, .wr_addr_i, .wr_data_i,
    .grant_o(ta_grant)
  );

  wdt_counter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .por_i, .stop_i,
    .restart_i(ta_grant && wr_data_i[CTL_RS_BIT]),
    .tmo_o(tmo), .cnt_o(cnt)
  );

  wdt_ctrl_regs u_regs (
    .clk_i, .rst_ni, .por_i, .ctl_wr_i(ctl_wr), .grant_i(ta_grant),
    .data_i(wr_data_i[2:0]), .tmo_i(tmo),
    .en_o(wdt_en_o), .restart_o(wdt_restart_o), .flag_o(wdt_flag_o),
    .cpu_rst_o
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int TIMEOUT = 122800,
  parameter int CNT_W   = $clog2(TIMEOUT)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_i,
  input logic             stop_i,
  input logic             cpu_rst_o,
  input logic             wdt_en_o,
  input logic             wdt_restart_o,
  input logic             wdt_flag_o,
  input logic             grant_i,
  input logic [CNT_W-1:0] cnt_i
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |=> !cpu_rst_o); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) < TIMEOUT); // R2
  AST_RST_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> $past(wdt_en_o)); // R3
  AST_RESTART_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_restart_o |=> !wdt_restart_o); // R4
  AST_ARM_ONLY_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wdt_en_o) |-> $past(grant_i)); // R6
  AST_RST_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> wdt_flag_o); // R8
  AST_NO_RST_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> !$past(stop_i)); // R9
  AST_POR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!wdt_flag_o && cnt_i == '0)); // R10
endmodule

bind wdt_keyed wdt_keyed_chk #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .por_i, .stop_i, .cpu_rst_o, .wdt_en_o, .wdt_restart_o,
  .wdt_flag_o, .grant_i(ta_grant), .cnt_i(cnt)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 24;

  logic       clk = 1'b0, rst_ni = 1'b0, por = 1'b0, stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic       cpu_rst, en, rs, flg;
  int         nvec = 0, nerr = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_keyed #(.TIMEOUT(T)) uut (
    .clk_i(clk), .rst_ni, .por_i(por), .stop_i(stop), .wr_en_i(wr_en),
    .wr_addr_i(addr), .wr_data_i(data), .cpu_rst_o(cpu_rst),
    .wdt_en_o(en), .wdt_restart_o(rs), .wdt_flag_o(flg)
  );

  // {addr, data, exp_en, exp_restart}
  localparam logic [10:0] VEC [0:14] = '{
    {1'b1, 8'h01, 1'b0, 1'b0},  // R6 locked write
    {1'b0, 8'hAA, 1'b0, 1'b0},
    {1'b0, 8'h55, 1'b0, 1'b0},
    {1'b1, 8'h01, 1'b1, 1'b0},  // R5 accepted
    {1'b1, 8'h00, 1'b1, 1'b0},  // R7 window used up
    {1'b0, 8'hAA, 1'b1, 1'b0},
    {1'b0, 8'h12, 1'b1, 1'b0},  // R7 bad key
    {1'b0, 8'h55, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'hAA, 1'b1, 1'b0},
    {1'b0, 8'h55, 1'b1, 1'b0},
    {1'b1, 8'h02, 1'b0, 1'b1},  // R4 restart readback
    {1'b0, 8'h55, 1'b0, 1'b0},  // R4 self-clear
    {1'b0, 8'h55, 1'b0, 1'b0},  // R7 second key without first
    {1'b1, 8'h01, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock_wr(input logic [7:0] d);
    wr(2'd0, 8'hAA); wr(2'd0, 8'h55); wr(2'd1, d);
  endtask

  task automatic wait_rst(output int n);
    n = 0;
    for (int i = 1; i <= 4 * T; i++) begin
      @(negedge clk);
      if (cpu_rst) begin n = i; break; end
    end
  endtask

  task automatic count_rst(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cpu_rst) hits++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 cpu_rst", cpu_rst, 0); chk("R1 en", en, 0);
    chk("R1 restart", rs, 0);      chk("R1 flag", flg, 0);

    for (int i = 0; i < 15; i++) begin
      wr({1'b0, VEC[i][10]}, VEC[i][9:2]);
      chk($sformatf("R5/R7 vec%0d en", i), en, int'(VEC[i][1]));
      chk($sformatf("R4 vec%0d restart", i), rs, int'(VEC[i][0]));
    end

    // R2 / R4: timeout interval and repeat
    unlock_wr(8'h03);
    wait_rst(n); chk("R4 restart to reset", n, T);
    wait_rst(n); chk("R2 back-to-back interval", n, T);
    @(negedge clk); chk("R2 pulse width", cpu_rst, 0);
    chk("R8 flag set", flg, 1); chk("R10 arm kept after wdt reset", en, 1);

    // R8 flag clear, R6 locked writes
    wr(2'd1, 8'h01); chk("R8 flag cleared", flg, 0);
    wr(2'd1, 8'h00); chk("R6 arm unchanged", en, 1);
    unlock_wr(8'h03);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h02);
    wait_rst(n); chk("R6 locked restart ignored", n, T - 6);

    // R7 window limits
    wr(2'd0, 8'hAA); wr(2'd0, 8'h55);
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h00); chk("R7 late write rejected", en, 1);
    wr(2'd0, 8'hAA); wr(2'd0, 8'h55);
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h00); chk("R5 last window cycle accepted", en, 0);
    wr(2'd0, 8'hAA);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h55); wr(2'd1, 8'h01); chk("R7 late second key", en, 0);

    // R3 free-running counter
    unlock_wr(8'h02);
    count_rst(2 * T, n); chk("R3 no reset when disarmed", n, 0);
    unlock_wr(8'h02);
    repeat (5) @(negedge clk);
    unlock_wr(8'h01);
    wait_rst(n); chk("R3 arm mid-interval", n, T - 8);

    // R9 stop mode
    unlock_wr(8'h03);
    repeat (5) @(negedge clk);
    stop = 1'b1; repeat (10) @(negedge clk); stop = 1'b0;
    wait_rst(n); chk("R9 stop holds count", n, T - 5);
    unlock_wr(8'h03);
    stop = 1'b1; count_rst(2 * T, n); stop = 1'b0;
    chk("R9 no reset in stop", n, 0);
    wait_rst(n); chk("R9 resume after stop", n, T);

    // R10 power-on reset event
    repeat (7) @(negedge clk);
    chk("R10 flag before por", flg, 1);
    por = 1'b1; @(negedge clk); por = 1'b0;
    chk("R10 flag cleared", flg, 0); chk("R10 arm kept", en, 1);
    wait_rst(n); chk("R10 count cleared", n, T);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule